// File: doc/BRIEF.md
# Cluster Coherency Control Register Block

This block is the memory-mapped register file of a small cluster coherency controller. The cluster has one to four processors, and the count is fixed at elaboration. A simple bus slave port gives access to the registers. The port carries an 8-bit byte offset into a 256-byte window, separate read and write strobes, a 32-bit write data word and an access size in bytes. Read data comes back one clock after the read strobe.

The block holds three things:
- a one-bit enable,
- a read-only configuration word computed from the processor count,
- a 32-bit power status word that can be written one byte lane at a time.

The power status word is addressed at four consecutive byte offsets. A write at lane offset k applies the size mask shifted up by k bytes. A read at lane offset k returns the whole word shifted down by k bytes. Some offsets are reserved for invalidate, filtering and access-control functions. These offsets, and every unlisted offset, read as zero and ignore writes. Reset clears only the enable bit. The power status word survives reset.

Top module: `ccr_regs`

## Requirements
- R1: A valid write to offset 0x00 stores only bit 0 of the write data. A read at 0x00 returns that bit in bit 0, with bits 31:1 zero.
- R2: A read at offset 0x04 returns ((2^N - 1) << 4) | (N - 1), where N is the processor count (NUM_CPU). Writes to 0x04 change nothing.
- R3: A valid write at offset 0x08+k (k = 0..3) replaces the status bits selected by (size mask << 8k), truncated to 32 bits, with (wdata << 8k). All other status bits keep their value. The size mask is 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2 and 4.
- R4: A read at offset 0x08+k returns the 32-bit status word logically shifted right by 8k bits, with zeros filled in at the top.
- R5: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other unlisted offset (including 0x01-0x03 and 0x05-0x07) read as zero. Writes to them leave control and status unchanged.
- R6: A write whose size_i is not 1, 2 or 4 changes no state.
- R7: While rst_ni is low the control bit is cleared. The status word keeps its value across reset.
- R8: Before its first write, the status word reads as zero.
- R9: rdata_o is registered. It is zero after reset. It updates on the clock edge at which rd_en_i is sampled high and holds its value otherwise. A read in the same cycle as a write returns the value from before the write.
- R10: A write takes effect on the clock edge at which wr_en_i is sampled high. A read issued on the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset within the register window |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| size_i | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions assume that addr_i, size_i and wdata_i carry known values whenever a strobe is high. They also assume that the status word is modified only by writes that pass the size check. The properties that predict read data assume no write to the same register in the same cycle.

The stimulus holds every input steady from one falling edge to the next. It issues reads alone, except in a single directed case that checks read-before-write ordering. Invalid sizes and random offsets are drawn deliberately so that the discard and ignore paths are exercised.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG,
    SEL_STAT
  } ccr_sel_e;

  typedef struct packed {
    ccr_sel_e   sel;
    logic [1:0] lane;
  } ccr_dec_t;

  function automatic logic size_valid(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [31:0] cfg_word(input int unsigned n);
    logic [31:0] cores;
    cores = (32'd1 << n) - 32'd1;
    return (cores << 4) | (n - 1);
  endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  OFF_CTRL = 8'h00,
  parameter logic [7:0]  OFF_CFG  = 8'h04,
  parameter logic [7:0]  OFF_STAT = 8'h08
) (
  input  logic [ADDR_W-1:0] addr_i,
  output ccr_dec_t          dec_o
);

  // status occupies one aligned 4-byte group
  localparam int unsigned GRP_HI = ADDR_W - 1;

  always_comb begin
    dec_o.sel  = SEL_NONE;
    dec_o.lane = addr_i[1:0];
    if (addr_i == ADDR_W'(OFF_CTRL)) begin
      dec_o.sel = SEL_CTRL;
    end else if (addr_i == ADDR_W'(OFF_CFG)) begin
      dec_o.sel = SEL_CFG;
    end else if (addr_i[GRP_HI:2] == OFF_STAT[GRP_HI:2]) begin
      dec_o.sel = SEL_STAT;
    end
  end

endmodule

// File: rtl/ccr_status.sv
module ccr_status #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [1:0]        lane_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o
);

  localparam int unsigned NB = DATA_W / 8;

  logic [DATA_W-1:0] wdata_sh;
  assign wdata_sh = wdata_i << (8 * lane_i);

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [7:0] byte_q = 8'h00;   // power-up value; not touched by reset
    logic       hit;

    always_comb begin
      hit = we_i
         && (j >= int'(lane_i))
         && ((j - int'(lane_i)) < int'(size_i));
    end

    always_ff @(posedge clk_i) begin
      if (hit) byte_q <= wdata_sh[8*j +: 8];
    end

    assign status_o[8*j +: 8] = byte_q;
  end

endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  ccr_dec_t          dec_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] cfg_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] data_o
);

  always_comb begin
    unique case (dec_i.sel)
      SEL_CTRL: data_o = DATA_W'(ctrl_i);
      SEL_CFG:  data_o = cfg_i;
      SEL_STAT: data_o = status_i >> (8 * dec_i.lane);
      default:  data_o = '0;
    endcase
  end

endmodule

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
#(
  parameter int unsigned NUM_CPU = 1,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
    $error("ccr_regs: NUM_CPU must be 1..4");
  end
  if (DATA_W != 32 || ADDR_W != 8) begin : g_bad_width
    $error("ccr_regs: layout assumes 8-bit offsets and 32-bit data");
  end

  localparam logic [DATA_W-1:0] CFG_VAL = DATA_W'(cfg_word(NUM_CPU));

  ccr_dec_t          dec;
  logic              wr_ok;
  logic              ctrl_q;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  ccr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  assign wr_ok = wr_en_i && size_valid(size_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= 1'b0;
    else if (wr_ok && dec.sel == SEL_CTRL) ctrl_q <= wdata_i[0];
  end

  ccr_status #(.DATA_W(DATA_W)) u_stat (
    .clk_i    (clk_i),
    .we_i     (wr_ok && dec.sel == SEL_STAT),
    .lane_i   (dec.lane),
    .size_i   (size_i),
    .wdata_i  (wdata_i),
    .status_o (status_w)
  );

  ccr_rdmux #(.DATA_W(DATA_W)) u_rd (
    .dec_i    (dec),
    .ctrl_i   (ctrl_q),
    .cfg_i    (CFG_VAL),
    .status_i (status_w),
    .data_o   (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ccr_regs_chk.sv
module ccr_regs_chk #(
  parameter int unsigned NUM_CPU = 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [2:0]  size_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        ctrl_q,
  input logic [31:0] status_w
);

  logic [31:0] cfg_exp;
  logic        zero_off;
  logic        bad_size;

  assign cfg_exp  = (((32'd1 << NUM_CPU) - 32'd1) << 4) | 32'(NUM_CPU - 1);
  assign zero_off = (addr_i == 8'h0C) || (addr_i == 8'h40) || (addr_i == 8'h44)
                 || (addr_i == 8'h50) || (addr_i == 8'h54) || (addr_i == 8'h01);
  assign bad_size = !((size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4));

  p_ctrl_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'h00) |=> (rdata_o[31:1] == 31'd0));

  p_cfg_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 8'h04) |=> (rdata_o == cfg_exp));

  p_stat_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i[7:2] == 6'd2)
      |=> (rdata_o == ($past(status_w) >> (8 * $past(addr_i[1:0])))));

  p_zero_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && zero_off) |=> (rdata_o == 32'd0));

  p_zero_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && zero_off) |=> ($stable(status_w) && $stable(ctrl_q)));

  p_bad_size_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bad_size) |=> ($stable(status_w) && $stable(ctrl_q)));

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_no_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(status_w) && $stable(ctrl_q)));

endmodule

bind ccr_regs ccr_regs_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .size_i   (size_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .ctrl_q   (ctrl_q),
  .status_w (status_w)
);

// File: tb/ccr_regs_tb.sv
`timescale 1ns/1ps
module ccr_regs_tb;

  localparam int unsigned NCPU = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  logic        m_ctrl = 1'b0;
  logic [31:0] m_stat = 32'd0;

  always #10 clk_i = ~clk_i;

  ccr_regs #(.NUM_CPU(NCPU)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [31:0] exp_cfg();
    logic [31:0] v = 32'd0;
    for (int i = 0; i < NCPU; i++) v[4+i] = 1'b1;
    v[3:0] = 4'(NCPU - 1);
    return v;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return {31'd0, m_ctrl};
    if (a == 8'h04) return exp_cfg();
    if (a >= 8'h08 && a <= 8'h0B) return m_stat >> (8 * (a - 8'h08));
    return 32'd0;
  endfunction

  function automatic void m_write(input logic [7:0] a, input logic [2:0] sz,
                                  input logic [31:0] d);
    logic [63:0] msk;
    int k;
    if (!(sz == 1 || sz == 2 || sz == 4)) return;
    if (a == 8'h00) m_ctrl = d[0];
    else if (a >= 8'h08 && a <= 8'h0B) begin
      k   = a - 8'h08;
      msk = (sz == 1) ? 64'hFF : (sz == 2) ? 64'hFFFF : 64'hFFFF_FFFF;
      msk = msk << (8 * k);
      m_stat = (m_stat & ~msk[31:0]) | (32'((64'(d) << (8 * k))) & msk[31:0]);
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; size_i = sz; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    m_write(a, sz, d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(req, rdata_o, m_read(a));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk_i);
    check("R9 reset rdata", rdata_o, 32'd0);
    rst_ni = 1'b1;

    rd_chk(8'h08, "R8 status power-up");
    rd_chk(8'h00, "R7 ctrl after reset");
    rd_chk(8'h04, "R2 config value");

    wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rd_chk(8'h00, "R1 ctrl set bit0 only");
    wr(8'h00, 3'd1, 32'hFFFF_FFFE);
    rd_chk(8'h00, "R1 ctrl clear");
    wr(8'h04, 3'd4, 32'hDEAD_BEEF);
    rd_chk(8'h04, "R2 config write ignored");

    wr(8'h08, 3'd4, 32'h1122_3344);
    rd_chk(8'h08, "R3 full word write");
    wr(8'h0A, 3'd1, 32'h0000_00AB);
    rd_chk(8'h08, "R3 byte lane 2");
    wr(8'h0B, 3'd2, 32'h0000_CDEF);
    rd_chk(8'h08, "R3 halfword at lane 3 truncated");
    wr(8'h09, 3'd4, 32'h5566_7788);
    rd_chk(8'h08, "R3 word at lane 1 truncated");
    rd_chk(8'h09, "R4 shift 8");
    rd_chk(8'h0A, "R4 shift 16");
    rd_chk(8'h0B, "R4 shift 24");

    wr(8'h0C, 3'd4, 32'hFFFF_FFFF);
    wr(8'h40, 3'd4, 32'hFFFF_FFFF);
    wr(8'h54, 3'd4, 32'hFFFF_FFFF);
    rd_chk(8'h08, "R5 reserved writes ignored");
    foreach (m_stat[i]) ;
    rd_chk(8'h0C, "R5 zero 0C");
    rd_chk(8'h40, "R5 zero 40");
    rd_chk(8'h44, "R5 zero 44");
    rd_chk(8'h50, "R5 zero 50");
    rd_chk(8'h54, "R5 zero 54");
    rd_chk(8'h02, "R5 zero 02");

    wr(8'h08, 3'd3, 32'h0);
    wr(8'h08, 3'd0, 32'h0);
    wr(8'h00, 3'd7, 32'h1);
    rd_chk(8'h08, "R6 bad size status");
    rd_chk(8'h00, "R6 bad size ctrl");

    // R9: simultaneous read and write returns old value; R10 next read sees new
    @(negedge clk_i);
    held = m_read(8'h08);
    addr_i = 8'h08; size_i = 3'd4; wdata_i = 32'hA5A5_0F0F;
    wr_en_i = 1'b1; rd_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    check("R9 read before write", rdata_o, held);
    m_write(8'h08, 3'd4, 32'hA5A5_0F0F);
    repeat (2) @(negedge clk_i);
    check("R9 rdata holds", rdata_o, held);
    rd_chk(8'h08, "R10 write visible next read");

    // R7: reset clears ctrl, keeps status
    wr(8'h00, 3'd1, 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_ctrl = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd_chk(8'h00, "R7 ctrl cleared");
    rd_chk(8'h08, "R7 status kept");

    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int pick = $urandom_range(0, 3);
      case (pick)
        0: a = 8'($urandom_range(0, 15));
        1: a = 8'($urandom_range(8, 11));
        2: a = 8'(($urandom_range(0, 4) == 0) ? 8'h40 : 8'h50 + 8'(4 * $urandom_range(0, 1)));
        default: a = 8'($urandom);
      endcase
      if ($urandom_range(0, 1) == 1)
        wr(a, 3'($urandom_range(0, 7)), $urandom);
      else
        rd_chk(a, "R3/R4/R5 random");
      if (n % 8 == 0) begin
        rd_chk(8'h08, "R3 random status");
        rd_chk(8'h00, "R1 random ctrl");
      end
    end

    finish_run();
  end

endmodule